// File: doc/BRIEF.md
# Six-Stage Pipeline Interlock and Forwarding Controller

This block is the hazard controller of an in-order pipeline whose stages run fetch, register read, address ALU, memory read, arithmetic ALU and write-back, one cycle each. Every cycle the datapath hands it a decoded description of the instruction in each decoded stage: a 3-bit class code plus the register numbers that stage cares about. The taken/not-taken outcome of a branch comparison also comes in from the arithmetic stage. From these inputs the controller drives, in the same cycle, a hold signal for each stage and a bubble-insert signal for each stage. It also drives the two data-memory grants and four forwarding-mux selects. One cycle after a taken branch it drives a PC redirect.

Memory operands are fetched before the arithmetic stage. A memory-to-memory ALU instruction reads data memory at the memory-read stage and writes the same address at write-back. When data memory has only one port, a reader meets an older writer two stages ahead, and the controller has to resolve that collision itself. A parameter selects a single shared data port or separate read and write ports.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Class codes are 0 empty, 1 reg-reg ALU, 2 reg-mem ALU, 3 mem-reg-mem ALU, 4 load, 5 store, 6 branch, and 7 is treated as empty. Classes 2, 3 and 4 read memory in the memory-read stage. Classes 3 and 5 write memory at write-back. Classes 1, 2 and 4 write a register. Stall and bubble vectors use bit 0 fetch, 1 register read, 2 address ALU, 3 memory read, 4 arithmetic ALU, 5 write-back. Forward selects use 00 register file, 01 arithmetic-stage result, 10 write-back-stage result. When every stage is empty, and during reset, all outputs are zero.
- R2: Suppose the register-read stage holds class 2, 3, 4 or 5 with a nonzero base register (src1), and the address stage holds a class 1, 2 or 4 writing that register. Then stall bits 0 and 1 and bubble bit 2 are set. No other combination of classes causes this interlock.
- R3: The address-stage base select serves classes 2 to 5 through src1. It is 01 when the arithmetic stage writes that register, otherwise 10 when write-back writes it, otherwise 00. The arithmetic stage wins when both match.
- R4: The store-data select serves a class 5 in the memory-read stage through src2, under the same rule as R3.
- R5: Operand A of the arithmetic stage is src1 of class 1 or 6. Operand B is src2 of class 1, 2, 3 or 6. Each select is 10 when write-back writes that register, otherwise 00.
- R6: Register 0 never causes an interlock and never yields a nonzero forward select.
- R7: With a single port, a reader in memory-read plus a writer in write-back grant only the write. They set stall bits 0 to 3 and bubble bit 4.
- R8: With a single port and no collision, a reader in memory-read gets the read grant and a writer in write-back gets the write grant.
- R9: With separate ports, reader and writer are both granted in the same cycle, with no stall.
- R10: A class 6 in the arithmetic stage with the taken input high sets bubble bits 1 to 4. It clears all stall bits and withholds the read grant. A not-taken branch changes nothing.
- R11: In the cycle after a taken branch, the PC redirect output is 1 and bubble bit 1 is set. Both drop again in the following cycle.
- R12: When the memory collision of R7 and the interlock of R2 occur together, the R7 result alone is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_cls_i | input | 3 | Class in register-read stage |
| rf_src1_i | input | REG_ADDR_W | Base register in register-read stage |
| a1_cls_i | input | 3 | Class in address stage |
| a1_src1_i | input | REG_ADDR_W | Base register in address stage |
| a1_dst_i | input | REG_ADDR_W | Destination in address stage |
| rd_cls_i | input | 3 | Class in memory-read stage |
| rd_src2_i | input | REG_ADDR_W | Store-data register in memory-read stage |
| rd_dst_i | input | REG_ADDR_W | Destination in memory-read stage |
| a2_cls_i | input | 3 | Class in arithmetic stage |
| a2_src1_i | input | REG_ADDR_W | Operand A register in arithmetic stage |
| a2_src2_i | input | REG_ADDR_W | Operand B register in arithmetic stage |
| a2_dst_i | input | REG_ADDR_W | Destination in arithmetic stage |
| a2_br_taken_i | input | 1 | Branch comparison outcome |
| wb_cls_i | input | 3 | Class in write-back stage |
| wb_dst_i | input | REG_ADDR_W | Destination in write-back stage |
| stall_o | output | 6 | Per-stage hold |
| bubble_o | output | 6 | Per-stage bubble insert at next edge |
| mem_rd_grant_o | output | 1 | Data-memory read grant |
| mem_wr_grant_o | output | 1 | Data-memory write grant |
| fwd_a1_base_o | output | 2 | Address-stage base select |
| fwd_rd_data_o | output | 2 | Store-data select |
| fwd_a2_a_o | output | 2 | Arithmetic operand A select |
| fwd_a2_b_o | output | 2 | Arithmetic operand B select |
| pc_redirect_o | output | 1 | Load branch target into PC |

## Verification
The bench builds two copies side by side with 5-bit register numbers. One copy uses the single shared data port, so read/write collisions, write priority and their precedence over the register interlock can be reached. The other uses separate ports, so the same collision stimulus can be shown to grant both accesses with no stall. The single-port copy also carries the taken-branch flush and the one-cycle redirect that follows it.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   localparam int CLS_W  = 3;
   localparam int NSTAGE = 6;

   localparam int ST_IF = 0;
   localparam int ST_RF = 1;
   localparam int ST_A1 = 2;
   localparam int ST_RD = 3;
   localparam int ST_A2 = 4;
   localparam int ST_WB = 5;

   typedef enum logic [CLS_W-1:0] {
      CL_NONE = 3'd0,
      CL_RR   = 3'd1,
      CL_RM   = 3'd2,
      CL_MRM  = 3'd3,
      CL_LD   = 3'd4,
      CL_ST   = 3'd5,
      CL_BR   = 3'd6,
      CL_RSV  = 3'd7
   } hzd_cls_e;

   localparam logic [1:0] FWD_REG = 2'b00;
   localparam logic [1:0] FWD_A2  = 2'b01;
   localparam logic [1:0] FWD_WB  = 2'b10;

   function automatic logic f_wr_reg(input logic [CLS_W-1:0] c);
      return (c == CL_RR) || (c == CL_RM) || (c == CL_LD);
   endfunction

   function automatic logic f_rd_mem(input logic [CLS_W-1:0] c);
      return (c == CL_RM) || (c == CL_MRM) || (c == CL_LD);
   endfunction

   function automatic logic f_wr_mem(input logic [CLS_W-1:0] c);
      return (c == CL_MRM) || (c == CL_ST);
   endfunction

   function automatic logic f_use_base(input logic [CLS_W-1:0] c);
      return (c == CL_RM) || (c == CL_MRM) || (c == CL_LD) || (c == CL_ST);
   endfunction

   function automatic logic f_use_a(input logic [CLS_W-1:0] c);
      return (c == CL_RR) || (c == CL_BR);
   endfunction

   function automatic logic f_use_b(input logic [CLS_W-1:0] c);
      return (c == CL_RR) || (c == CL_RM) || (c == CL_MRM) || (c == CL_BR);
   endfunction

endpackage

// File: rtl/hzd_fwd_mux.sv
module hzd_fwd_mux
   import hzd_pkg::*;
#(
   parameter int REG_ADDR_W = 5,
   parameter bit USE_ALU2   = 1'b1
) (
   input  logic                  need_i,
   input  logic [REG_ADDR_W-1:0] src_i,
   input  logic [CLS_W-1:0]      a2_cls_i,
   input  logic [REG_ADDR_W-1:0] a2_dst_i,
   input  logic [CLS_W-1:0]      wb_cls_i,
   input  logic [REG_ADDR_W-1:0] wb_dst_i,
   output logic [1:0]            sel_o
);

   logic live;
   logic a2_hit;
   logic wb_hit;

   // register 0 is hardwired and never needs a bypass
   assign live   = need_i && (src_i != '0);
   // the arithmetic-stage path exists only for consumers younger than it
   assign a2_hit = USE_ALU2 && f_wr_reg(a2_cls_i) && (a2_dst_i == src_i);
   assign wb_hit = f_wr_reg(wb_cls_i) && (wb_dst_i == src_i);

   always_comb begin
      sel_o = FWD_REG;
      if (live) begin
         if (a2_hit)      sel_o = FWD_A2;
         else if (wb_hit) sel_o = FWD_WB;
      end
   end

endmodule

// File: rtl/hzd_mem_arb.sv
module hzd_mem_arb #(
   parameter bit DUAL_MEM_PORT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req_i,
   input  logic wr_req_i,
   input  logic kill_rd_i,
   output logic rd_gnt_o,
   output logic wr_gnt_o,
   output logic conflict_o
);

   logic rd_live;
   assign rd_live  = rd_req_i && !kill_rd_i;
   assign wr_gnt_o = wr_req_i;

   generate
      if (DUAL_MEM_PORT) begin : g_dual
         assign rd_gnt_o   = rd_live;
         assign conflict_o = 1'b0;

         AST_DUAL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_live && wr_req_i) |-> (rd_gnt_o && wr_gnt_o)); // R9
      end else begin : g_single
         assign conflict_o = rd_live && wr_req_i;
         assign rd_gnt_o   = rd_live && !wr_req_i;

         AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_gnt_o && wr_gnt_o)); // R7
      end
   endgenerate

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_i |-> wr_gnt_o); // R8

endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
   import hzd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_flush_i,
   input  logic              mem_conf_i,
   input  logic              data_haz_i,
   output logic [NSTAGE-1:0] stall_o,
   output logic [NSTAGE-1:0] bubble_o,
   output logic              redirect_o
);

   logic redir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) redir_q <= 1'b0;
      else        redir_q <= br_flush_i;
   end

   assign redirect_o = redir_q;

   // priority: branch flush, redirect kill, memory collision, data interlock
   always_comb begin
      stall_o  = '0;
      bubble_o = '0;
      if (br_flush_i) begin
         for (int k = ST_RF; k <= ST_A2; k++) bubble_o[k] = 1'b1;
      end else if (redir_q) begin
         bubble_o[ST_RF] = 1'b1;
      end else if (mem_conf_i) begin
         for (int k = ST_IF; k <= ST_RD; k++) stall_o[k] = 1'b1;
         bubble_o[ST_A2] = 1'b1;
      end else if (data_haz_i) begin
         stall_o[ST_IF]  = 1'b1;
         stall_o[ST_RF]  = 1'b1;
         bubble_o[ST_A1] = 1'b1;
      end
   end

   AST_REDIRECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      br_flush_i |=> (redirect_o && bubble_o[ST_RF])); // R11

   AST_FLUSH_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      br_flush_i |-> ((stall_o == '0) && bubble_o[ST_A2] && bubble_o[ST_RF])); // R10

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
   import hzd_pkg::*;
#(
   parameter int REG_ADDR_W    = 5,
   parameter bit DUAL_MEM_PORT = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            rf_cls_i,
   input  logic [REG_ADDR_W-1:0] rf_src1_i,
   input  logic [2:0]            a1_cls_i,
   input  logic [REG_ADDR_W-1:0] a1_src1_i,
   input  logic [REG_ADDR_W-1:0] a1_dst_i,
   input  logic [2:0]            rd_cls_i,
   input  logic [REG_ADDR_W-1:0] rd_src2_i,
   input  logic [REG_ADDR_W-1:0] rd_dst_i,
   input  logic [2:0]            a2_cls_i,
   input  logic [REG_ADDR_W-1:0] a2_src1_i,
   input  logic [REG_ADDR_W-1:0] a2_src2_i,
   input  logic [REG_ADDR_W-1:0] a2_dst_i,
   input  logic                  a2_br_taken_i,
   input  logic [2:0]            wb_cls_i,
   input  logic [REG_ADDR_W-1:0] wb_dst_i,
   output logic [5:0]            stall_o,
   output logic [5:0]            bubble_o,
   output logic                  mem_rd_grant_o,
   output logic                  mem_wr_grant_o,
   output logic [1:0]            fwd_a1_base_o,
   output logic [1:0]            fwd_rd_data_o,
   output logic [1:0]            fwd_a2_a_o,
   output logic [1:0]            fwd_a2_b_o,
   output logic                  pc_redirect_o
);

   localparam int          NOPS      = 4;
   localparam bit [NOPS-1:0] OP_A2PATH = 4'b0011;

   generate
      if (REG_ADDR_W < 1 || REG_ADDR_W > 8) begin : g_bad_w
         $error("pipe_hazard_ctrl: REG_ADDR_W out of range");
      end
      if (NSTAGE != 6) begin : g_bad_s
         $error("pipe_hazard_ctrl: stage count mismatch");
      end
   endgenerate

   logic br_flush;
   logic mem_conf;
   logic data_haz;
   logic rd_req;
   logic wr_req;

   assign br_flush = (a2_cls_i == CL_BR) && a2_br_taken_i;
   assign rd_req   = f_rd_mem(rd_cls_i);
   assign wr_req   = f_wr_mem(wb_cls_i);

   // the address stage cannot take a value from the stage just ahead of it
   assign data_haz = f_use_base(rf_cls_i) && (rf_src1_i != '0)
                     && f_wr_reg(a1_cls_i) && (a1_dst_i == rf_src1_i);

   logic                  op_need [NOPS];
   logic [REG_ADDR_W-1:0] op_src  [NOPS];
   logic [1:0]            op_sel  [NOPS];

   assign op_need[0] = f_use_base(a1_cls_i);
   assign op_src[0]  = a1_src1_i;
   assign op_need[1] = (rd_cls_i == CL_ST);
   assign op_src[1]  = rd_src2_i;
   assign op_need[2] = f_use_a(a2_cls_i);
   assign op_src[2]  = a2_src1_i;
   assign op_need[3] = f_use_b(a2_cls_i);
   assign op_src[3]  = a2_src2_i;

   generate
      for (genvar g = 0; g < NOPS; g++) begin : g_op
         hzd_fwd_mux #(
            .REG_ADDR_W (REG_ADDR_W),
            .USE_ALU2   (OP_A2PATH[g])
         ) u_mux (
            .need_i   (op_need[g]),
            .src_i    (op_src[g]),
            .a2_cls_i (a2_cls_i),
            .a2_dst_i (a2_dst_i),
            .wb_cls_i (wb_cls_i),
            .wb_dst_i (wb_dst_i),
            .sel_o    (op_sel[g])
         );
      end
   endgenerate

   assign fwd_a1_base_o = op_sel[0];
   assign fwd_rd_data_o = op_sel[1];
   assign fwd_a2_a_o    = op_sel[2];
   assign fwd_a2_b_o    = op_sel[3];

   hzd_mem_arb #(.DUAL_MEM_PORT(DUAL_MEM_PORT)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req_i   (rd_req),
      .wr_req_i   (wr_req),
      .kill_rd_i  (br_flush),
      .rd_gnt_o   (mem_rd_grant_o),
      .wr_gnt_o   (mem_wr_grant_o),
      .conflict_o (mem_conf)
   );

   hzd_interlock u_ilk (
      .clk        (clk),
      .rst_n      (rst_n),
      .br_flush_i (br_flush),
      .mem_conf_i (mem_conf),
      .data_haz_i (data_haz),
      .stall_o    (stall_o),
      .bubble_o   (bubble_o),
      .redirect_o (pc_redirect_o)
   );

   // rd_dst_i travels with the descriptor; no rule consumes it
   logic unused_rd_dst;
   assign unused_rd_dst = ^rd_dst_i;

   AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (a1_src1_i == '0) |-> (fwd_a1_base_o == 2'b00)); // R6

   AST_MEM_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ((DUAL_MEM_PORT == 1'b0) && rd_req && wr_req && !br_flush && !pc_redirect_o)
      |-> (stall_o[3] && bubble_o[4] && !mem_rd_grant_o)); // R7

   AST_RAW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (f_use_base(rf_cls_i) && (rf_src1_i != '0) && f_wr_reg(a1_cls_i)
       && (a1_dst_i == rf_src1_i) && !br_flush && !pc_redirect_o)
      |-> (stall_o[1] && stall_o[0])); // R2

endmodule

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;

   localparam int RW = 5;
   localparam logic [2:0] NO = 3'd0, RR = 3'd1, RM = 3'd2, MR = 3'd3,
                          LD = 3'd4, ST = 3'd5, BR = 3'd6;

   typedef struct packed {
      logic [3:0] req;
      logic [2:0] rfc; logic [4:0] rfs;
      logic [2:0] a1c; logic [4:0] a1s; logic [4:0] a1d;
      logic [2:0] rdc; logic [4:0] rds; logic [4:0] rdd;
      logic [2:0] a2c; logic [4:0] a2s1; logic [4:0] a2s2; logic [4:0] a2d; logic a2t;
      logic [2:0] wbc; logic [4:0] wbd;
      logic [5:0] xst; logic [5:0] xbb; logic xrg; logic xwg;
      logic [1:0] xf0; logic [1:0] xf1; logic [1:0] xf2; logic [1:0] xf3;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      // R1 all empty
      '{4'd1, NO,5'd0, NO,5'd0,5'd0, NO,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, NO,5'd0, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0},
      // R2 load base produced by reg-reg in address stage
      '{4'd2, LD,5'd3, RR,5'd0,5'd3, NO,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, NO,5'd0, 6'b000011,6'b000100, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0},
      // R2 store ahead writes no register
      '{4'd2, LD,5'd3, ST,5'd0,5'd3, NO,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, NO,5'd0, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0},
      // R2 reg-reg consumer needs no base
      '{4'd2, RR,5'd3, LD,5'd0,5'd3, NO,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, NO,5'd0, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0},
      // R6 base register 0
      '{4'd6, ST,5'd0, LD,5'd1,5'd0, NO,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, NO,5'd0, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0},
      // R3 arithmetic stage beats write-back
      '{4'd3, NO,5'd0, LD,5'd7,5'd0, NO,5'd0,5'd0, RR,5'd1,5'd2,5'd7,1'b0, LD,5'd7, 6'b000000,6'b000000, 1'b0,1'b0, 2'd1,2'd0,2'd0,2'd0},
      // R3 write-back source
      '{4'd3, NO,5'd0, RM,5'd7,5'd0, NO,5'd0,5'd0, BR,5'd1,5'd2,5'd7,1'b0, RM,5'd7, 6'b000000,6'b000000, 1'b0,1'b0, 2'd2,2'd0,2'd0,2'd0},
      // R4 store data from arithmetic stage
      '{4'd4, NO,5'd0, NO,5'd0,5'd0, ST,5'd9,5'd0, LD,5'd0,5'd0,5'd9,1'b0, NO,5'd0, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd1,2'd0,2'd0},
      // R4 store data from write-back
      '{4'd4, NO,5'd0, NO,5'd0,5'd0, ST,5'd9,5'd0, NO,5'd0,5'd0,5'd0,1'b0, RR,5'd9, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd2,2'd0,2'd0},
      // R5 reg-reg operand B from write-back
      '{4'd5, NO,5'd0, NO,5'd0,5'd0, NO,5'd0,5'd0, RR,5'd4,5'd5,5'd0,1'b0, LD,5'd5, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd2},
      // R5 mem-reg-mem uses only operand B
      '{4'd5, NO,5'd0, NO,5'd0,5'd0, NO,5'd0,5'd0, MR,5'd4,5'd4,5'd0,1'b0, RM,5'd4, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd2},
      // R6 branch on register 0
      '{4'd6, NO,5'd0, NO,5'd0,5'd0, NO,5'd0,5'd0, BR,5'd0,5'd0,5'd0,1'b0, LD,5'd0, 6'b000000,6'b000000, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0},
      // R7 load meets store
      '{4'd7, NO,5'd0, NO,5'd0,5'd0, LD,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, ST,5'd0, 6'b001111,6'b010000, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0},
      // R7 mem-reg-mem meets mem-reg-mem
      '{4'd7, NO,5'd0, NO,5'd0,5'd0, MR,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, MR,5'd0, 6'b001111,6'b010000, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0},
      // R8 read alone
      '{4'd8, NO,5'd0, NO,5'd0,5'd0, RM,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, RR,5'd0, 6'b000000,6'b000000, 1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0},
      // R8 write alone
      '{4'd8, NO,5'd0, NO,5'd0,5'd0, ST,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, ST,5'd0, 6'b000000,6'b000000, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0},
      // R12 memory collision dominates register interlock
      '{4'd12, LD,5'd3, RR,5'd0,5'd3, LD,5'd0,5'd0, NO,5'd0,5'd0,5'd0,1'b0, ST,5'd0, 6'b001111,6'b010000, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [2:0]    rf_cls, a1_cls, rd_cls, a2_cls, wb_cls;
   logic [RW-1:0] rf_src1, a1_src1, a1_dst, rd_src2, rd_dst;
   logic [RW-1:0] a2_src1, a2_src2, a2_dst, wb_dst;
   logic          a2_tk;

   logic [5:0] s_st, s_bb, d_st, d_bb;
   logic       s_rg, s_wg, s_rd, d_rg, d_wg, d_rd;
   logic [1:0] s_f0, s_f1, s_f2, s_f3, d_f0, d_f1, d_f2, d_f3;

   pipe_hazard_ctrl #(.REG_ADDR_W(RW), .DUAL_MEM_PORT(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .rf_cls_i(rf_cls), .rf_src1_i(rf_src1),
      .a1_cls_i(a1_cls), .a1_src1_i(a1_src1), .a1_dst_i(a1_dst),
      .rd_cls_i(rd_cls), .rd_src2_i(rd_src2), .rd_dst_i(rd_dst),
      .a2_cls_i(a2_cls), .a2_src1_i(a2_src1), .a2_src2_i(a2_src2), .a2_dst_i(a2_dst),
      .a2_br_taken_i(a2_tk), .wb_cls_i(wb_cls), .wb_dst_i(wb_dst),
      .stall_o(s_st), .bubble_o(s_bb), .mem_rd_grant_o(s_rg), .mem_wr_grant_o(s_wg),
      .fwd_a1_base_o(s_f0), .fwd_rd_data_o(s_f1), .fwd_a2_a_o(s_f2), .fwd_a2_b_o(s_f3),
      .pc_redirect_o(s_rd)
   );

   pipe_hazard_ctrl #(.REG_ADDR_W(RW), .DUAL_MEM_PORT(1'b1)) dut_dp_i (
      .clk(clk), .rst_n(rst_n),
      .rf_cls_i(rf_cls), .rf_src1_i(rf_src1),
      .a1_cls_i(a1_cls), .a1_src1_i(a1_src1), .a1_dst_i(a1_dst),
      .rd_cls_i(rd_cls), .rd_src2_i(rd_src2), .rd_dst_i(rd_dst),
      .a2_cls_i(a2_cls), .a2_src1_i(a2_src1), .a2_src2_i(a2_src2), .a2_dst_i(a2_dst),
      .a2_br_taken_i(a2_tk), .wb_cls_i(wb_cls), .wb_dst_i(wb_dst),
      .stall_o(d_st), .bubble_o(d_bb), .mem_rd_grant_o(d_rg), .mem_wr_grant_o(d_wg),
      .fwd_a1_base_o(d_f0), .fwd_rd_data_o(d_f1), .fwd_a2_a_o(d_f2), .fwd_a2_b_o(d_f3),
      .pc_redirect_o(d_rd)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   function automatic logic [22:0] s_out();
      return {s_st, s_bb, s_rg, s_wg, s_f0, s_f1, s_f2, s_f3, s_rd};
   endfunction

   function automatic logic [22:0] d_out();
      return {d_st, d_bb, d_rg, d_wg, d_f0, d_f1, d_f2, d_f3, d_rd};
   endfunction

   task automatic chk(input string tag, input logic [22:0] act, input logic [22:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      rf_cls = v.rfc; rf_src1 = v.rfs;
      a1_cls = v.a1c; a1_src1 = v.a1s; a1_dst = v.a1d;
      rd_cls = v.rdc; rd_src2 = v.rds; rd_dst = v.rdd;
      a2_cls = v.a2c; a2_src1 = v.a2s1; a2_src2 = v.a2s2; a2_dst = v.a2d; a2_tk = v.a2t;
      wb_cls = v.wbc; wb_dst = v.wbd;
   endtask

   task automatic idle();
      vec_t z;
      z = '0;
      drive(z);
   endtask

   initial begin
      idle();
      // R1 reset state
      repeat (2) @(posedge clk);
      @(negedge clk); #5;
      chk("R1 reset", s_out(), 23'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(TBL[i]);
         #5;
         chk($sformatf("R%0d vector %0d", TBL[i].req, i), s_out(),
             {TBL[i].xst, TBL[i].xbb, TBL[i].xrg, TBL[i].xwg,
              TBL[i].xf0, TBL[i].xf1, TBL[i].xf2, TBL[i].xf3, 1'b0});
      end

      // R9 separate ports: collision grants both, no stall
      @(negedge clk);
      idle(); rd_cls = LD; wb_cls = ST;
      #5;
      chk("R9 dual collision", d_out(), {6'b0, 6'b0, 1'b1, 1'b1, 8'd0, 1'b0});

      // R10 not-taken branch changes nothing
      @(negedge clk);
      idle(); a2_cls = BR; a2_tk = 1'b0;
      #5;
      chk("R10 not taken", s_out(), 23'd0);
      @(negedge clk);
      idle();
      #5;
      chk("R11 no redirect after not taken", s_out(), 23'd0);

      // R10 taken branch with a pending load and store
      @(negedge clk);
      idle(); a2_cls = BR; a2_tk = 1'b1; rd_cls = LD; wb_cls = ST;
      #5;
      chk("R10 taken flush", s_out(), {6'b0, 6'b011110, 1'b0, 1'b1, 8'd0, 1'b0});

      // R11 redirect cycle, branch now in write-back
      @(negedge clk);
      idle(); wb_cls = BR;
      #5;
      chk("R11 redirect", s_out(), {6'b0, 6'b000010, 1'b0, 1'b0, 8'd0, 1'b1});

      @(negedge clk);
      idle();
      #5;
      chk("R11 redirect drops", s_out(), 23'd0);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule